// File: doc/BRIEF.md
# AXI Write Burst Splitter

This block sits on the write path between an AXI4 manager and a memory-side subordinate that cannot take long bursts. The manager may issue incrementing write bursts of 1 to 256 beats on a 256-bit data path, which is 32 bytes per beat. Each accepted burst is re-issued downstream as a short chain of sub-bursts. Every sub-burst is as long as it can be. None is longer than 128 beats, and none crosses a 4 KB address boundary.

Write data passes through unchanged and in order. The downstream last-beat flag is rebuilt so that it marks the end of each sub-burst. The block collects the write responses of all sub-bursts and returns a single response to the manager, carrying the most severe code it saw. Only one burst is handled at a time, with a single transaction ID. The block flags any upstream last-beat marker that does not match the requested length.

Top module: `axi_wr_splitter`

## Requirements
- R1: An upstream burst with length field L results in exactly L+1 data beats downstream, spread over one or more sub-bursts, and the first sub-burst starts at the upstream address.
- R2: No downstream sub-burst carries more than 128 beats, so its length field is at most 127.
- R3: No sub-burst crosses a 4 KB boundary. Each sub-burst length is the smallest of three values: the beats still owed, 128, and the beats left before the next 4 KB boundary, counted from the start address rounded down to a 32-byte multiple.
- R4: Each sub-burst after the first starts at the previous start address, rounded down to a 32-byte multiple, plus 32 bytes times the previous beat count.
- R5: Write data and strobes reach the downstream side unchanged and in order. Downstream WLAST is 1 exactly on the final beat of every sub-burst. Downstream WVALID is never high without upstream WVALID, and upstream WREADY is never high without downstream WREADY.
- R6: Upstream AWREADY is 1 when the block is idle. It stays 0 from the acceptance of a burst until its merged response has completed its handshake.
- R7: Exactly one upstream write response is returned, and only after every sub-burst response has arrived. Its code is the numerically largest of the sub-burst codes: DECERR (3), then SLVERR (2), then EXOKAY (1), then OKAY (0).
- R8: `wlast_err` is high for one cycle, in the cycle after any accepted upstream beat whose WLAST differs from whether that beat is the final beat of the burst. It stays 0 for correctly framed bursts.
- R9: While downstream AWVALID is high and AWREADY is low, the downstream address and length hold steady. While upstream BVALID is high and BREADY is low, BVALID and BRESP hold steady.
- R10: After reset the block is idle. Upstream AWREADY is 1, upstream WREADY is 0, upstream BVALID is 0, and downstream AWVALID and WVALID are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Upstream burst start address |
| s_awlen | input | 8 | Upstream burst length minus one |
| s_awvalid | input | 1 | Upstream address valid |
| s_awready | output | 1 | Upstream address ready |
| s_wdata | input | DATA_W | Upstream write data |
| s_wstrb | input | DATA_W/8 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last-beat marker |
| s_wvalid | input | 1 | Upstream data valid |
| s_wready | output | 1 | Upstream data ready |
| s_bresp | output | 2 | Merged response code |
| s_bvalid | output | 1 | Merged response valid |
| s_bready | input | 1 | Upstream response ready |
| m_awaddr | output | ADDR_W | Sub-burst start address |
| m_awlen | output | 8 | Sub-burst length minus one |
| m_awvalid | output | 1 | Sub-burst address valid |
| m_awready | input | 1 | Downstream address ready |
| m_wdata | output | DATA_W | Forwarded write data |
| m_wstrb | output | DATA_W/8 | Forwarded byte strobes |
| m_wlast | output | 1 | Last beat of the current sub-burst |
| m_wvalid | output | 1 | Forwarded data valid |
| m_wready | input | 1 | Downstream data ready |
| m_bresp | input | 2 | Sub-burst response code |
| m_bvalid | input | 1 | Sub-burst response valid |
| m_bready | output | 1 | Sub-burst response ready |
| wlast_err | output | 1 | Pulse marking a misframed upstream beat |

## Verification
The hardest case to reach is a full 256-beat burst that breaks into three sub-bursts of different lengths, with the worst response code arriving on the middle one. The downstream address and data sides must also drift apart in time, so that the two independent split walks are really compared. The stimulus gets there in three ways. It starts one beat below a 4 KB boundary. It gives each sub-burst its own injected response code. It throttles downstream AWREADY and WREADY with patterns of coprime period, so address and data handshakes land in different cycles from burst to burst. An unaligned start just below a boundary, and lengths ending exactly on or one beat past a boundary, cover the rounding in the split arithmetic.

// File: rtl/axi_split_pkg.sv
`timescale 1ns/1ps
package axi_split_pkg;

  typedef logic [1:0] resp_t;
  localparam resp_t RESP_OKAY = 2'b00;

  // Beats that fit between a page offset (rounded down to a beat) and the page end.
  function automatic int unsigned beats_before_page(input int unsigned page_off,
                                                    input int unsigned page_bytes,
                                                    input int unsigned beat_bytes);
    int unsigned base;
    base = page_off - (page_off % beat_bytes);
    return (page_bytes - base) / beat_bytes;
  endfunction

  // Sub-burst length: the tightest of the three limits.
  function automatic int unsigned clip_len(input int unsigned remaining,
                                           input int unsigned to_page,
                                           input int unsigned cap);
    int unsigned n;
    n = remaining;
    if (cap < n) n = cap;
    if (to_page < n) n = to_page;
    return n;
  endfunction

  // Keep the more severe of two response codes (larger code wins).
  function automatic resp_t merge_resp(input resp_t acc, input resp_t nxt);
    return (nxt > acc) ? nxt : acc;
  endfunction

endpackage

// File: rtl/split_aw_planner.sv
`timescale 1ns/1ps
module split_aw_planner
  import axi_split_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned SUBC_W     = 3,
  parameter int unsigned PAGE_W     = 12,
  parameter int unsigned BEAT_SHIFT = 5,
  parameter int unsigned MAX_BEATS  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [LEN_W-1:0]  s_awlen,
  input  logic              s_awvalid,
  output logic              s_awready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [LEN_W-1:0]  m_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  input  logic              burst_done,
  output logic              cmd_take,
  output logic              all_issued,
  output logic [SUBC_W-1:0] subs_issued
);
  localparam int unsigned BEAT_BYTES = 1 << BEAT_SHIFT;
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;

  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  sub_beats;
  logic [ADDR_W-1:0] next_addr;
  logic              aw_fire;

  always_comb begin
    sub_beats = CNT_W'(clip_len(32'(remain),
                                beats_before_page(32'(cur_addr[PAGE_W-1:0]), PAGE_BYTES, BEAT_BYTES),
                                MAX_BEATS));
  end

  assign next_addr  = {cur_addr[ADDR_W-1:BEAT_SHIFT], {BEAT_SHIFT{1'b0}}}
                    + (ADDR_W'(sub_beats) << BEAT_SHIFT);
  assign s_awready  = !busy;
  assign cmd_take   = s_awvalid && !busy;
  assign m_awvalid  = busy && (remain != '0);
  assign m_awaddr   = cur_addr;
  assign m_awlen    = LEN_W'(sub_beats - 1'b1);
  assign aw_fire    = m_awvalid && m_awready;
  assign all_issued = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur_addr    <= '0;
      remain      <= '0;
      subs_issued <= '0;
    end else if (cmd_take) begin
      busy        <= 1'b1;
      cur_addr    <= s_awaddr;
      remain      <= CNT_W'(s_awlen) + 1'b1;
      subs_issued <= '0;
    end else if (aw_fire) begin
      cur_addr    <= next_addr;
      remain      <= remain - sub_beats;
      subs_issued <= subs_issued + 1'b1;
    end else if (burst_done) begin
      busy        <= 1'b0;
    end
  end

endmodule

// File: rtl/split_w_path.sv
`timescale 1ns/1ps
module split_w_path
  import axi_split_pkg::*;
#(
  parameter int unsigned DATA_W     = 256,
  parameter int unsigned STRB_W     = 32,
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned PAGE_W     = 12,
  parameter int unsigned BEAT_SHIFT = 5,
  parameter int unsigned MAX_BEATS  = 128,
  parameter int unsigned IDX_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_take,
  input  logic [PAGE_W-1:0] cmd_off,
  input  logic [CNT_W-1:0]  cmd_beats,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wlast,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  output logic              wlast_err,
  output logic              w_fire,
  output logic              w_sub_end
);
  localparam int unsigned BEAT_BYTES = 1 << BEAT_SHIFT;
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_W-1:0] w_off;
  logic [CNT_W-1:0]  w_rem;
  logic [IDX_W-1:0]  beat_idx;
  logic [CNT_W-1:0]  w_sub;
  logic              active;
  logic              final_beat;

  always_comb begin
    w_sub = CNT_W'(clip_len(32'(w_rem),
                            beats_before_page(32'(w_off), PAGE_BYTES, BEAT_BYTES),
                            MAX_BEATS));
  end

  assign active     = (w_rem != '0);
  assign m_wvalid   = s_wvalid && active;
  assign s_wready   = m_wready && active;
  assign m_wdata    = s_wdata;
  assign m_wstrb    = s_wstrb;
  assign m_wlast    = active && (beat_idx == IDX_W'(w_sub - 1'b1));
  assign w_fire     = m_wvalid && m_wready;
  assign w_sub_end  = w_fire && m_wlast;
  assign final_beat = m_wlast && (w_rem == w_sub);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_off     <= '0;
      w_rem     <= '0;
      beat_idx  <= '0;
      wlast_err <= 1'b0;
    end else begin
      wlast_err <= w_fire && (s_wlast != final_beat);
      if (cmd_take) begin
        w_off    <= cmd_off;
        w_rem    <= cmd_beats;
        beat_idx <= '0;
      end else if (w_sub_end) begin
        w_off    <= {w_off[PAGE_W-1:BEAT_SHIFT], {BEAT_SHIFT{1'b0}}}
                  + (PAGE_W'(w_sub) << BEAT_SHIFT);
        w_rem    <= w_rem - w_sub;
        beat_idx <= '0;
      end else if (w_fire) begin
        beat_idx <= beat_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/split_b_merge.sv
`timescale 1ns/1ps
module split_b_merge
  import axi_split_pkg::*;
#(
  parameter int unsigned SUBC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  resp_t             m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output resp_t             s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic              all_issued,
  input  logic [SUBC_W-1:0] subs_issued,
  output logic              burst_done
);
  logic              hold;
  logic [SUBC_W-1:0] got;
  resp_t             worst;
  logic              b_fire;
  logic              report;

  assign m_bready   = !hold;
  assign b_fire     = m_bvalid && !hold;
  assign report     = all_issued && !hold && (got == subs_issued);
  assign s_bvalid   = hold;
  assign s_bresp    = worst;
  assign burst_done = hold && s_bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= 1'b0;
      got   <= '0;
      worst <= RESP_OKAY;
    end else if (burst_done) begin
      hold  <= 1'b0;
      got   <= '0;
      worst <= RESP_OKAY;
    end else if (b_fire) begin
      got   <= got + 1'b1;
      worst <= merge_resp(worst, m_bresp);
    end else if (report) begin
      hold  <= 1'b1;
    end
  end

endmodule

// File: rtl/axi_wr_splitter.sv
`timescale 1ns/1ps
module axi_wr_splitter #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 256,
  parameter int unsigned MAX_BEATS  = 128,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic [7:0]            s_awlen,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [DATA_W-1:0]     s_wdata,
  input  logic [DATA_W/8-1:0]   s_wstrb,
  input  logic                  s_wlast,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  output logic [ADDR_W-1:0]     m_awaddr,
  output logic [7:0]            m_awlen,
  output logic                  m_awvalid,
  input  logic                  m_awready,
  output logic [DATA_W-1:0]     m_wdata,
  output logic [DATA_W/8-1:0]   m_wstrb,
  output logic                  m_wlast,
  output logic                  m_wvalid,
  input  logic                  m_wready,
  input  logic [1:0]            m_bresp,
  input  logic                  m_bvalid,
  output logic                  m_bready,
  output logic                  wlast_err
);
  localparam int unsigned LEN_W      = 8;
  localparam int unsigned CNT_W      = LEN_W + 1;
  localparam int unsigned STRB_W     = DATA_W / 8;
  localparam int unsigned BEAT_SHIFT = $clog2(STRB_W);
  localparam int unsigned PAGE_W     = $clog2(PAGE_BYTES);
  localparam int unsigned IDX_W      = $clog2(MAX_BEATS);
  localparam int unsigned PAGE_BEATS = PAGE_BYTES / STRB_W;
  localparam int unsigned SUB_UNIT   = (MAX_BEATS < PAGE_BEATS) ? MAX_BEATS : PAGE_BEATS;
  localparam int unsigned MAX_SUBS   = (1 << LEN_W) / SUB_UNIT + 2;
  localparam int unsigned SUBC_W     = $clog2(MAX_SUBS + 1);

  // Named internal events, visible to the bound checker.
  logic              cmd_take;
  logic              all_issued;
  logic [SUBC_W-1:0] subs_issued;
  logic              burst_done;
  logic              w_fire;
  logic              w_sub_end;

  split_aw_planner #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .SUBC_W(SUBC_W),
    .PAGE_W(PAGE_W), .BEAT_SHIFT(BEAT_SHIFT), .MAX_BEATS(MAX_BEATS)
  ) u_aw (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .burst_done(burst_done), .cmd_take(cmd_take),
    .all_issued(all_issued), .subs_issued(subs_issued)
  );

  split_w_path #(
    .DATA_W(DATA_W), .STRB_W(STRB_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W),
    .BEAT_SHIFT(BEAT_SHIFT), .MAX_BEATS(MAX_BEATS), .IDX_W(IDX_W)
  ) u_w (
    .clk(clk), .rst_n(rst_n),
    .cmd_take(cmd_take), .cmd_off(s_awaddr[PAGE_W-1:0]), .cmd_beats(CNT_W'(s_awlen) + 1'b1),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .wlast_err(wlast_err), .w_fire(w_fire), .w_sub_end(w_sub_end)
  );

  split_b_merge #(
    .SUBC_W(SUBC_W)
  ) u_b (
    .clk(clk), .rst_n(rst_n),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .all_issued(all_issued), .subs_issued(subs_issued), .burst_done(burst_done)
  );

endmodule

// File: rtl/axi_wr_splitter_chk.sv
`timescale 1ns/1ps
module axi_wr_splitter_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned MAX_BEATS  = 128,
  parameter int unsigned PAGE_W     = 12,
  parameter int unsigned BEAT_SHIFT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic [1:0]        s_bresp,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [7:0]        m_awlen,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic              m_wvalid,
  input logic              m_wready
);
  localparam int unsigned IW         = PAGE_W - BEAT_SHIFT;
  localparam int unsigned SW         = ((IW > 8) ? IW : 8) + 2;
  localparam int unsigned PAGE_BEATS = 1 << IW;

  logic [SW-1:0] aw_end_beat;
  assign aw_end_beat = SW'(m_awaddr[PAGE_W-1:BEAT_SHIFT]) + SW'(m_awlen) + SW'(1);

  AST_SUB_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (32'(m_awlen) < MAX_BEATS)); // R2
  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (32'(aw_end_beat) <= PAGE_BEATS)); // R3
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen))); // R9
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp))); // R9
  AST_AW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> !s_awready); // R6
  AST_W_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    s_wready |-> m_wready); // R5
  AST_W_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> s_wvalid); // R5

endmodule

bind axi_wr_splitter axi_wr_splitter_chk #(
  .ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .PAGE_W(PAGE_W), .BEAT_SHIFT(BEAT_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_awready(s_awready), .s_wvalid(s_wvalid), .s_wready(s_wready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awvalid(m_awvalid), .m_awready(m_awready),
  .m_wvalid(m_wvalid), .m_wready(m_wready)
);

// File: tb/tb_axi_wr_splitter.sv
`timescale 1ns/1ps
module tb_axi_wr_splitter;
  localparam int AW = 32;
  localparam int DW = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] s_awaddr = '0;
  logic [7:0] s_awlen = '0;
  logic s_awvalid = 1'b0, s_awready;
  logic [DW-1:0] s_wdata = '0;
  logic [DW/8-1:0] s_wstrb = '1;
  logic s_wlast = 1'b0, s_wvalid = 1'b0, s_wready;
  logic [1:0] s_bresp;
  logic s_bvalid, s_bready = 1'b0;
  logic [AW-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic m_awvalid, m_awready = 1'b0;
  logic [DW-1:0] m_wdata;
  logic [DW/8-1:0] m_wstrb;
  logic m_wlast, m_wvalid, m_wready = 1'b0;
  logic [1:0] m_bresp = 2'b00;
  logic m_bvalid = 1'b0, m_bready;
  logic wlast_err;

  always #2.5 clk = ~clk;

  axi_wr_splitter dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .wlast_err(wlast_err)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // Downstream model logs
  logic [31:0] awa [512];
  logic [7:0]  awl [512];
  logic [31:0] wlo [1024];
  logic [31:0] whi [1024];
  bit          wls [1024];
  int aw_n = 0, w_n = 0, wl_n = 0, b_sent = 0, b_base = 0, err_n = 0, cyc = 0;
  logic [5:0] cur_resp = '0;

  always begin
    @(negedge clk);
    cyc++;
    m_awready = (cyc % 3) != 1;
    m_wready  = (cyc % 7) != 3;
    if (rst_n && b_sent < aw_n && b_sent < wl_n) begin
      m_bvalid = 1'b1;
      m_bresp  = cur_resp[2*(b_sent-b_base) +: 2];
    end else begin
      m_bvalid = 1'b0;
      m_bresp  = 2'b00;
    end
    #1;
    if (m_awvalid && m_awready) begin awa[aw_n] = m_awaddr; awl[aw_n] = m_awlen; aw_n++; end
    if (m_wvalid && m_wready) begin
      wlo[w_n] = m_wdata[31:0]; whi[w_n] = m_wdata[DW-1:DW-32]; wls[w_n] = m_wlast; w_n++;
      if (m_wlast) wl_n++;
    end
    if (m_bvalid && m_bready) b_sent++;
    if (wlast_err) err_n++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int burst_id = 0;

  task automatic run_burst(input logic [31:0] addr, input logic [7:0] len, input logic [5:0] resp,
                           input int bad_beat, input int exp_err);
    int aw0, w0, e0, ex_n, cnt, lenv;
    int unsigned base_al, ba;
    int unsigned ex_a [4];
    int ex_l [4];
    bit lastbit [256];
    bit leak, holdbad, dbad, lbad;
    logic [1:0] r, exp_r;
    logic [31:0] tag;
    lenv = int'(len);
    // expected split, walked beat by beat
    base_al = addr & ~32'h1F;
    ex_n = 0; cnt = 0;
    for (int i = 0; i <= lenv; i++) begin
      ba = base_al + 32 * i;
      if (i == 0 || cnt == 128 || (ba % 4096) == 0) begin
        ex_a[ex_n] = (i == 0) ? addr : ba; ex_l[ex_n] = 0; ex_n++; cnt = 0;
      end
      ex_l[ex_n-1]++; cnt++;
    end
    for (int i = 0; i < 256; i++) lastbit[i] = 0;
    cnt = 0;
    for (int k = 0; k < ex_n; k++) begin cnt += ex_l[k]; lastbit[cnt-1] = 1; end
    exp_r = 2'b00;
    for (int k = 0; k < ex_n; k++) if (resp[2*k +: 2] > exp_r) exp_r = resp[2*k +: 2];

    burst_id++;
    leak = 0; holdbad = 0;
    @(negedge clk);
    aw0 = aw_n; w0 = w_n; e0 = err_n; b_base = b_sent; cur_resp = resp;
    s_awvalid = 1; s_awaddr = addr; s_awlen = len;
    #1; while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk); s_awvalid = 0;
    for (int i = 0; i <= lenv; i++) begin
      if (i % 5 == 4) begin s_wvalid = 0; @(negedge clk); end
      tag = {burst_id[15:0], i[15:0]};
      s_wvalid = 1; s_wdata = {8{tag}};
      s_wlast = (bad_beat >= 0) ? (i == bad_beat) : (i == lenv);
      #1; if (s_awready) leak = 1;
      while (!s_wready) begin @(negedge clk); #1; if (s_awready) leak = 1; end
      @(negedge clk);
    end
    s_wvalid = 0; s_wlast = 0;
    #1; while (!s_bvalid) begin if (s_awready) leak = 1; @(negedge clk); #1; end
    r = s_bresp;
    repeat (2) begin
      @(negedge clk); #1;
      if (!s_bvalid || s_bresp != r) holdbad = 1;
      if (s_awready) leak = 1;
    end
    @(negedge clk); s_bready = 1;
    @(negedge clk); s_bready = 0; #1;
    chk(s_awready && !s_bvalid, "R6 release", s_awready, 1);
    repeat (2) @(negedge clk);

    chk(aw_n - aw0 == ex_n, "R1 sub count", aw_n - aw0, ex_n);
    chk(w_n - w0 == lenv + 1, "R1 beat count", w_n - w0, lenv + 1);
    if (aw_n - aw0 == ex_n) begin
      for (int k = 0; k < ex_n; k++) begin
        chk(awa[aw0+k] == ex_a[k], (k == 0) ? "R1 first addr" : "R4 sub addr", awa[aw0+k], ex_a[k]);
        chk(int'(awl[aw0+k]) == ex_l[k] - 1, "R3 sub len", awl[aw0+k], ex_l[k] - 1);
        chk(awl[aw0+k] < 8'd128, "R2 cap", awl[aw0+k], 127);
      end
    end
    dbad = 0; lbad = 0;
    for (int i = 0; i <= lenv && i < w_n - w0; i++) begin
      tag = {burst_id[15:0], i[15:0]};
      if (wlo[w0+i] != tag || whi[w0+i] != tag) dbad = 1;
      if (wls[w0+i] != lastbit[i]) lbad = 1;
    end
    chk(!dbad, "R5 data", dbad, 0);
    chk(!lbad, "R5 wlast", lbad, 0);
    chk(r == exp_r, "R7 bresp", r, exp_r);
    chk(!leak, "R6 awready while busy", leak, 0);
    chk(!holdbad, "R9 b hold", holdbad, 0);
    chk(err_n - e0 == exp_err, "R8 wlast_err count", err_n - e0, exp_err);
  endtask

  localparam logic [45:0] VECS [9] = '{
    {32'h0000_1000, 8'd0,   6'b000000},
    {32'h0000_0000, 8'd127, 6'b000000},
    {32'h0001_0000, 8'd128, 6'b000100},
    {32'h0000_2000, 8'd255, 6'b001000},
    {32'h0000_0FE0, 8'd255, 6'b101100},
    {32'h0000_0800, 8'd99,  6'b000010},
    {32'h0000_3F00, 8'd7,   6'b000011},
    {32'h0000_3F00, 8'd8,   6'b000000},
    {32'h0000_0FF0, 8'd1,   6'b000000}
  };

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R10 reset state
    chk(s_awready == 1'b1, "R10 awready", s_awready, 1);
    chk(!m_awvalid && !m_wvalid && !s_bvalid && !s_wready, "R10 idle outputs",
        {m_awvalid, m_wvalid, s_bvalid, s_wready}, 0);
    for (int v = 0; v < 9; v++) begin
      run_burst(VECS[v][45:14], VECS[v][13:6], VECS[v][5:0], -1, 0);
    end
    // R8: misframed last marker on a two-beat burst flags both beats
    run_burst(32'h0000_5000, 8'd1, 6'b000000, 0, 2);
    // R8: correct framing after an error raises nothing
    run_burst(32'h0000_5040, 8'd2, 6'b000001, -1, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule